// File: doc/BRIEF.md
# Half-Warp Banked Scratchpad Arbiter

This block sits in front of a word-interleaved on-chip scratchpad that is split into sixteen single-port banks. A group of sixteen lanes issues one request at a time. The request carries sixteen word addresses, a participation mask, a direction flag (load or store) and one data word per lane. The arbiter works out which lanes collide on the same bank. It then spreads the colliding lanes over consecutive cycles, so that each bank serves one distinct address per cycle. When it finishes, it raises a one-cycle completion pulse and presents each lane's load result on a wide output bus.

Lanes that name the very same word are merged into one bank access. For loads this gives a broadcast, and for stores a single winner is chosen. Only distinct addresses inside a bank cost extra cycles. The service time is therefore set by the busiest bank and not by the total lane count. The sixteen bank storage arrays are part of the block.

Top module: `scratch_bank_arbiter`

## Requirements
- R1: A request is taken on a rising edge where `req_valid` is 1 and `busy` is 0. `busy` reads 1 from the next cycle until completion. A request presented while `busy` is 1 is ignored: it neither stores data nor changes the outcome of the request in progress.
- R2: A word address selects bank `addr mod 16` (the low 4 bits) and row `addr / 16` (the upper bits), so consecutive words fall in consecutive banks.
- R3: When every participating lane maps to a different bank, `done` is 1 in the cycle right after the accepting edge (latency 1).
- R4: The latency, counted in clock edges from the accepting edge to the edge that raises `done`, equals the largest number of distinct addresses that the participating lanes place in any one bank.
- R5: A unit word stride or any one-to-one bank permutation completes in 1 cycle. Stride 2 takes 2 cycles, stride 4 takes 4, stride 8 takes 8, and stride 16 takes 16.
- R6: A load where all lanes name one address completes in 1 cycle, and every lane receives that word.
- R7: After a load completes, lane t's field of `rd_data` (bits t*32 upward) holds the word stored at its address. Non-participating lanes keep their previous value. A store request leaves all of `rd_data` unchanged.
- R8: A store writes each participating lane's word to its address. Masked-off lanes write nothing. When several participating lanes store to one address, the data of the highest-numbered of those lanes is kept.
- R9: After reset, `busy` and `done` are 0 and `rd_data` is all zeros. `done` is a single-cycle pulse, and `busy` is 0 in the cycle where `done` is 1.
- R10: A request with an all-zero mask completes with latency 1 and changes neither the storage nor `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store request, 0 = load request |
| req_mask | input | 16 | Lane participation, bit t for lane t |
| req_addr | input | 128 | Eight-bit word address per lane, lane t in bits t*8+7..t*8 |
| req_wdata | input | 512 | Store word per lane, lane t in bits t*32+31..t*32 |
| busy | output | 1 | Request in progress; new requests are not taken |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 512 | Load result per lane, lane t in bits t*32+31..t*32 |

## Verification
Errors in the pending-lane set or the per-bank leader choice show up at the ports as a wrong latency. The `done` pulse then arrives early, late or never, within at most sixteen cycles of acceptance. A wrong bank or row mapping, or a broken merge of identical addresses, appears as a wrong word on some lane of `rd_data` in the same cycle as `done`. For stores, the error shows on the next load that reads the affected address. Stride patterns with known conflict degrees pin the latency, and a bench model of the storage pins every returned word.

// File: rtl/scb_pkg.sv
package scb_pkg;
    localparam int SCB_LANES = 16;
    localparam int SCB_BANKS = 16;
    localparam int SCB_AW    = 8;
    localparam int SCB_DW    = 32;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } arb_state_t;
endpackage

// File: rtl/bank_lane_pick.sv
module bank_lane_pick #(
    parameter int NTHR    = 16,
    parameter int AW      = 8,
    parameter int DW      = 32,
    parameter int BW      = 4,
    parameter int BANK_ID = 0,
    localparam int RW     = AW - BW
) (
    input  logic [NTHR-1:0]         pending,
    input  logic [NTHR-1:0][AW-1:0] lane_addr,
    input  logic [NTHR-1:0][DW-1:0] lane_wdata,
    output logic [NTHR-1:0]         serve,
    output logic                    hit,
    output logic [RW-1:0]           row,
    output logic [DW-1:0]           wdata
);
    localparam logic [BW-1:0] MY_BANK = BW'(BANK_ID);

    logic [AW-1:0] lead_addr;

    // lowest pending lane in this bank picks the address for this pass
    always_comb begin
        hit       = 1'b0;
        lead_addr = '0;
        for (int t = 0; t < NTHR; t++) begin
            if (!hit && pending[t] && lane_addr[t][BW-1:0] == MY_BANK) begin
                hit       = 1'b1;
                lead_addr = lane_addr[t];
            end
        end
    end

    // every pending lane naming the leader's word rides along; last one wins stores
    always_comb begin
        wdata = '0;
        for (int t = 0; t < NTHR; t++) begin
            serve[t] = hit && pending[t] && (lane_addr[t] == lead_addr);
            if (serve[t])
                wdata = lane_wdata[t];
        end
    end

    assign row = lead_addr[AW-1:BW];
endmodule

// File: rtl/bank_store.sv
module bank_store #(
    parameter int RW = 4,
    parameter int DW = 32,
    localparam int DEPTH = 1 << RW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [RW-1:0] row,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[row] <= wdata;
    end

    assign rdata = mem[row];
endmodule

// File: rtl/scratch_bank_arbiter.sv
module scratch_bank_arbiter
    import scb_pkg::*;
#(
    parameter int NTHR  = SCB_LANES,
    parameter int NBANK = SCB_BANKS,
    parameter int AW    = SCB_AW,
    parameter int DW    = SCB_DW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [NTHR-1:0]    req_mask,
    input  logic [NTHR*AW-1:0] req_addr,
    input  logic [NTHR*DW-1:0] req_wdata,
    output logic               busy,
    output logic               done,
    output logic [NTHR*DW-1:0] rd_data
);
    localparam int BW = $clog2(NBANK);
    localparam int RW = AW - BW;
    localparam int CW = $clog2(NTHR + 2) + 1;

    arb_state_t              state;
    logic                    op_write;
    logic [NTHR-1:0]         pending;
    logic [NTHR-1:0][AW-1:0] lane_addr;
    logic [NTHR-1:0][DW-1:0] lane_wdata;
    logic [NTHR-1:0][DW-1:0] rd_q;
    logic                    done_q;
    logic [CW-1:0]           svc_cnt;

    logic [NTHR-1:0][AW-1:0]  req_addr_a;
    logic [NTHR-1:0][DW-1:0]  req_wdata_a;
    logic [NBANK-1:0][NTHR-1:0] serve_b;
    logic [NBANK-1:0]          hit_b;
    logic [NBANK-1:0][RW-1:0]  row_b;
    logic [NBANK-1:0][DW-1:0]  wdata_b;
    logic [NBANK-1:0][DW-1:0]  rdata_b;
    logic [NTHR-1:0]           serve_all;
    logic [NTHR-1:0]           pending_nx;
    logic                      accept;

    assign req_addr_a  = req_addr;
    assign req_wdata_a = req_wdata;
    assign accept      = req_valid && (state == ST_IDLE);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        bank_lane_pick #(
            .NTHR(NTHR), .AW(AW), .DW(DW), .BW(BW), .BANK_ID(b)
        ) u_pick (
            .pending   (pending),
            .lane_addr (lane_addr),
            .lane_wdata(lane_wdata),
            .serve     (serve_b[b]),
            .hit       (hit_b[b]),
            .row       (row_b[b]),
            .wdata     (wdata_b[b])
        );

        bank_store #(.RW(RW), .DW(DW)) u_store (
            .clk  (clk),
            .we   ((state == ST_RUN) && op_write && hit_b[b]),
            .row  (row_b[b]),
            .wdata(wdata_b[b]),
            .rdata(rdata_b[b])
        );
    end

    always_comb begin
        serve_all = '0;
        for (int b = 0; b < NBANK; b++)
            serve_all = serve_all | serve_b[b];
    end

    assign pending_nx = pending & ~serve_all;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            op_write   <= 1'b0;
            pending    <= '0;
            lane_addr  <= '0;
            lane_wdata <= '0;
            rd_q       <= '0;
            done_q     <= 1'b0;
            svc_cnt    <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state      <= ST_RUN;
                        op_write   <= req_write;
                        pending    <= req_mask;
                        lane_addr  <= req_addr_a;
                        lane_wdata <= req_wdata_a;
                        svc_cnt    <= '0;
                    end
                end
                ST_RUN: begin
                    pending <= pending_nx;
                    svc_cnt <= svc_cnt + 1'b1;
                    if (!op_write) begin
                        for (int t = 0; t < NTHR; t++) begin
                            if (serve_all[t])
                                rd_q[t] <= rdata_b[lane_addr[t][BW-1:0]];
                        end
                    end
                    if (pending_nx == '0) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state == ST_RUN);
    assign done    = done_q;
    assign rd_data = rd_q;

    // no lane may join the pending set while a request is in flight
    assert_no_join_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |=> ((pending & ~$past(pending)) == '0));

    // each service pass retires at least one lane
    assert_progress_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && pending != '0) |=> ($countones(pending) < $countones($past(pending))));

    // service never outlasts one pass per lane
    assert_svc_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (svc_cnt <= CW'(NTHR)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_drained_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (pending == '0 && !busy && $past(busy)));
endmodule

// File: tb/sim_scratch_bank_arbiter.sv
module sim_scratch_bank_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 16;
    localparam int NROW = 12;

    // pattern table: lane t uses address (BASE + t*STRIDE) mod 256
    localparam int T_STRIDE [NROW] = '{1, 2, 8, 16, 4, 3, 0, 2, 8, 5, 16, 32};
    localparam int T_BASE   [NROW] = '{0, 0, 0, 5, 1, 2, 8'h37, 0, 3, 7, 0, 0};
    localparam int T_MASK   [NROW] = '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF,
                                       16'hFFFF, 16'h00FF, 16'h0003, 16'hFFFF, 16'h0F0F, 16'hFFFF};
    localparam int T_LAT    [NROW] = '{1, 2, 8, 16, 4, 1, 1, 1, 1, 1, 8, 8};

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic [NT-1:0]   req_mask = '0;
    logic [NT*8-1:0] req_addr = '0;
    logic [NT*32-1:0] req_wdata = '0;
    logic            busy, done;
    logic [NT*32-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0] mdl [256];
    logic [31:0] exp_rd [NT];
    logic [7:0]  ta [NT];
    logic [31:0] td [NT];

    scratch_bank_arbiter u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_mask(req_mask), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] pat(input int a, input int salt);
        return {8'h5A, 8'(a), 8'(salt), 8'(~a)};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic check_rd(input string req);
        bit ok = 1;
        int bad = 0;
        for (int t = 0; t < NT; t++) begin
            if (ok && rd_data[t*32 +: 32] !== exp_rd[t]) begin
                ok = 0;
                bad = t;
            end
        end
        chk(ok, req, $sformatf("rd_data lane %0d", bad), rd_data[bad*32 +: 32], exp_rd[bad]);
    endtask

    // drives one request, updates the bench model, returns latency in edges
    task automatic issue(input bit wr, input logic [15:0] m, input int intrude, output int lat);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_mask  = m;
        for (int t = 0; t < NT; t++) begin
            req_addr[t*8 +: 8]   = ta[t];
            req_wdata[t*32 +: 32] = td[t];
        end
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (1) begin
            @(negedge clk);
            lat++;
            if (intrude > 0 && lat == 2) begin
                req_valid = 1'b1;
                req_write = 1'b1;
                req_mask  = 16'hFFFF;
                for (int t = 0; t < NT; t++) begin
                    req_addr[t*8 +: 8]    = 8'(8'h80 + t);
                    req_wdata[t*32 +: 32] = 32'hDEAD0000 + t;
                end
            end
            if (intrude > 0 && lat == 5)
                req_valid = 1'b0;
            if (done || lat > 40) break;
        end
        for (int t = 0; t < NT; t++) begin
            if (m[t]) begin
                if (wr) mdl[ta[t]] = td[t];
                else    exp_rd[t] = mdl[ta[t]];
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int lat;
        logic [31:0] snap [NT];
        for (int t = 0; t < NT; t++) exp_rd[t] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        chk(busy == 1'b0, "R9", "busy after reset", 32'(busy), 0);
        chk(done == 1'b0, "R9", "done after reset", 32'(done), 0);
        check_rd("R9");

        // fill all 256 words; stride 1 is conflict-free (R3, R8)
        for (int k = 0; k < 16; k++) begin
            for (int t = 0; t < NT; t++) begin
                ta[t] = 8'(k*16 + t);
                td[t] = pat(k*16 + t, 1);
            end
            issue(1'b1, 16'hFFFF, 0, lat);
            if (k == 0) chk(lat == 1, "R3", "fill latency", 32'(lat), 1);
        end

        // table walk: latency (R4, R5, R6) and returned data (R2, R7)
        for (int r = 0; r < NROW; r++) begin
            for (int t = 0; t < NT; t++) begin
                ta[t] = 8'(T_BASE[r] + t*T_STRIDE[r]);
                td[t] = '0;
            end
            issue(1'b0, 16'(T_MASK[r]), 0, lat);
            chk(lat == T_LAT[r], "R4/R5", $sformatf("latency row %0d", r), 32'(lat), 32'(T_LAT[r]));
            check_rd("R2/R7");
            @(negedge clk);
            chk(done == 1'b0, "R9", "done width", 32'(done), 0);
        end

        // R6: broadcast gives every lane the same word in 1 cycle
        for (int t = 0; t < NT; t++) ta[t] = 8'h9C;
        issue(1'b0, 16'hFFFF, 0, lat);
        chk(lat == 1, "R6", "broadcast latency", 32'(lat), 1);
        chk(rd_data[15*32 +: 32] == pat(8'h9C, 1), "R6", "broadcast lane 15",
            rd_data[15*32 +: 32], pat(8'h9C, 1));

        // R4: mixed pattern, bank 3 holds 3,19,35 (3 distinct), others clean
        for (int t = 0; t < NT; t++) ta[t] = 8'(t);
        ta[0] = 8'd3; ta[1] = 8'd19; ta[2] = 8'd35; ta[3] = 8'd3; ta[4] = 8'd19;
        issue(1'b0, 16'hFFFF, 0, lat);
        chk(lat == 3, "R4", "mixed bank-3 latency", 32'(lat), 3);
        check_rd("R4");

        // R8: three lanes store one address; highest lane wins
        for (int t = 0; t < NT; t++) begin
            ta[t] = 8'h21;
            td[t] = 32'hC0DE0000 + t;
        end
        issue(1'b1, 16'h1208, 0, lat);
        chk(lat == 1, "R8", "merged store latency", 32'(lat), 1);
        issue(1'b0, 16'hFFFF, 0, lat);
        chk(rd_data[0 +: 32] == 32'hC0DE000C, "R8", "same-address winner",
            rd_data[0 +: 32], 32'hC0DE000C);

        // R8: masked-off lane 5 must not store
        for (int t = 0; t < NT; t++) begin
            ta[t] = 8'(8'h40 + t);
            td[t] = 32'hBEEF0000 + t;
        end
        issue(1'b1, 16'hFFDF, 0, lat);
        issue(1'b0, 16'hFFFF, 0, lat);
        chk(rd_data[5*32 +: 32] == pat(8'h45, 1), "R8", "masked lane store",
            rd_data[5*32 +: 32], pat(8'h45, 1));
        check_rd("R8");

        // R7: partial-mask load; other lanes hold
        for (int t = 0; t < NT; t++) ta[t] = 8'(8'hA0 + t);
        issue(1'b0, 16'h0005, 0, lat);
        check_rd("R7");

        // R7: store leaves rd_data unchanged
        for (int t = 0; t < NT; t++) snap[t] = rd_data[t*32 +: 32];
        for (int t = 0; t < NT; t++) begin
            ta[t] = 8'(8'hE0 + t);
            td[t] = pat(8'hE0 + t, 2);
        end
        issue(1'b1, 16'hFFFF, 0, lat);
        chk(rd_data[2*32 +: 32] == snap[2], "R7", "rd_data after store",
            rd_data[2*32 +: 32], snap[2]);

        // R10: empty mask
        issue(1'b1, 16'h0000, 0, lat);
        chk(lat == 1, "R10", "empty mask latency", 32'(lat), 1);
        issue(1'b0, 16'h0000, 0, lat);
        chk(rd_data[2*32 +: 32] == snap[2], "R10", "rd_data after empty",
            rd_data[2*32 +: 32], snap[2]);

        // R1: request offered while busy is ignored
        for (int t = 0; t < NT; t++) ta[t] = 8'(2 + 16*t);
        @(negedge clk);
        issue(1'b0, 16'hFFFF, 1, lat);
        chk(lat == 16, "R1", "latency with intruder", 32'(lat), 16);
        check_rd("R1");
        for (int t = 0; t < NT; t++) ta[t] = 8'(8'h80 + t);
        issue(1'b0, 16'hFFFF, 0, lat);
        check_rd("R1");
        chk(busy == 1'b0, "R9", "busy low with done", 32'(busy), 0);

        // R1: busy rises the cycle after acceptance
        for (int t = 0; t < NT; t++) ta[t] = 8'(16*t);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_mask = 16'hFFFF;
        for (int t = 0; t < NT; t++) req_addr[t*8 +: 8] = ta[t];
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R1", "busy after accept", 32'(busy), 1);
        repeat (20) @(negedge clk);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule